// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer with Capture and Pulse Output

This block is a 16-bit up-counter shared by four modes of operation. In the compare-clear timer mode it counts up to the value in data register A, wraps to zero, raises an interrupt pulse and toggles a compare pin. In capture mode it runs freely and copies the count into data register B on each rising edge of a capture input. In the two pulse-generation modes it drives a PWM pin that is high from count zero until the count reaches B, with a period that ends when the count reaches A. The one-shot variant makes one period and stops. The repeat variant runs without end.

The counter is advanced by a one-cycle enable. That enable comes from a prescaler on the system clock with one of seven fixed ratios, or from the rising edges of an external count pin. Software uses one shared address bus to write the two data registers and a control register, and to read them back together with the live count.

Top module: `mt16_timer`

## Requirements
- R1: After a synchronous reset the count, data register B and the control register read 0, data register A reads 16'hFFFF, and irq, cmp_out and pwm_out are low.
- R2: The control field csel (bits 2:0) values 0..6 advance the counter once every 1, 2, 4, 8, 64, 512 or 2048 clocks. After a control write that changes csel or sets the clear bit, the first advance comes that many clocks after the write edge. The counter only advances while the start bit (bit 6) is 1.
- R3: With csel = 7 the counter advances once per rising edge of ext_clk, three clock edges after the pin rises. A level held high gives only one advance.
- R4: In mode 0 (timer), an advance taken while the count equals A sets the count to 0 and raises irq for one cycle.
- R5: cmp_out toggles on each mode-0 match and keeps its level in all other modes.
- R6: A control write with bit 7 set clears the count to 0 and restarts the prescaler, in any mode. Bit 7 always reads back as 0.
- R7: In mode 1 (capture) the counter wraps freely. A rising edge on cap_in loads B with the count that is present two edges after the pin rises, and raises irq for one cycle. The counter is not disturbed.
- R8: Rising edges on cap_in in any mode other than 1 leave B unchanged and raise no irq.
- R9: In modes 2 and 3, pwm_out is high while start is 1 and the count is below B. An advance at count A returns the count to 0 and pulses irq.
- R10: Mode 3 (repeat) starts each new period without software action.
- R11: In mode 2 (one-shot) the end of the period clears the start bit and leaves the count at 0, so pwm_out stays low until start is written again.
- R12: The address map is: 0 for A, 1 for B, 2 for control (mode in bits 5:4), and 3 for the count, which is read-only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register at addr |
| addr | input | 2 | Register select for writes and reads |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data of the register at addr |
| ext_clk | input | 1 | Asynchronous external count input |
| cap_in | input | 1 | Asynchronous capture trigger |
| irq | output | 1 | One-cycle interrupt pulse on match, period end or capture |
| cmp_out | output | 1 | Compare pin, toggles on timer-mode match |
| pwm_out | output | 1 | Pulse-generation output |

## Verification
The hardest cases to reach are the slow prescaler ratios and the edges of the synchroniser. For the divide-by-2048 ratio, the stimulus clears the counter in the same control write that selects the ratio. It then samples the count one clock before and one clock after the first advance. For the external clock and capture inputs, the stimulus raises the pin between edges and reads the result on exactly the third edge. It also holds the pin high and shows that no second event follows. The one-shot stop is checked twice: the bench restarts it by writing the start bit again and watches it stop a second time.

// File: rtl/mt16_pkg.sv
package mt16_pkg;

    localparam int CNT_W    = 16;
    localparam int PRE_W    = 11;

    typedef enum logic [1:0] {
        MD_COUNT = 2'd0,
        MD_CAPT  = 2'd1,
        MD_ONCE  = 2'd2,
        MD_LOOP  = 2'd3
    } mode_e;

    typedef struct packed {
        logic       start;
        mode_e      mode;
        logic [2:0] csel;
    } ctrl_t;

    localparam logic [2:0] CSEL_EXT = 3'd7;

    localparam logic [1:0] ADR_A   = 2'd0;
    localparam logic [1:0] ADR_B   = 2'd1;
    localparam logic [1:0] ADR_CTL = 2'd2;
    localparam logic [1:0] ADR_CNT = 2'd3;

    localparam int BIT_CLR   = 7;
    localparam int BIT_START = 6;

    // log2 of the division ratio for each internal clock select
    function automatic logic [3:0] div_shift(input logic [2:0] sel);
        case (sel)
            3'd0:    div_shift = 4'd0;
            3'd1:    div_shift = 4'd1;
            3'd2:    div_shift = 4'd2;
            3'd3:    div_shift = 4'd3;
            3'd4:    div_shift = 4'd6;
            3'd5:    div_shift = 4'd9;
            3'd6:    div_shift = 4'd11;
            default: div_shift = 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/mt16_edge.sv
module mt16_edge #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [SYNC_N:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[SYNC_N-1:0], din};
    end

    assign rise = chain_q[SYNC_N-1] & ~chain_q[SYNC_N];

    // a detected edge lasts exactly one cycle
    assert_rise_single_R3: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/mt16_prescale.sv
module mt16_prescale
    import mt16_pkg::*;
#(
    parameter int PW = PRE_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic [2:0] sel,
    output logic       tick
);
    logic [PW-1:0] pre_q;
    logic [PW-1:0] lim;

    always_comb lim = PW'((32'd1 << div_shift(sel)) - 32'd1);

    assign tick = (pre_q == lim);

    always_ff @(posedge clk) begin
        if (rst || clr)  pre_q <= '0;
        else if (tick)   pre_q <= '0;
        else             pre_q <= pre_q + 1'b1;
    end

    // any ratio above one cannot tick in back-to-back cycles
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && lim != '0 && !clr) |=> !tick);
endmodule

// File: rtl/mt16_timer.sv
module mt16_timer
    import mt16_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    addr,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] rd_data,
    input  logic          ext_clk,
    input  logic          cap_in,
    output logic          irq,
    output logic          cmp_out,
    output logic          pwm_out
);
    ctrl_t         ctl_q;
    logic [CW-1:0] a_q, b_q, cnt_q;
    logic          irq_q, cmp_q;

    logic ext_rise, cap_rise, pre_tick;
    logic ctl_wr, sw_clr, csel_chg, pre_clr;
    logic tick, step, at_top, wraps, period_end, cap_hit, ppg_mode;

    assign ctl_wr     = wr_en && (addr == ADR_CTL);
    assign sw_clr     = ctl_wr && wr_data[BIT_CLR];
    assign csel_chg   = ctl_wr && (wr_data[2:0] != ctl_q.csel);
    assign pre_clr    = sw_clr || csel_chg || period_end;

    assign tick       = (ctl_q.csel == CSEL_EXT) ? ext_rise : pre_tick;
    assign step       = ctl_q.start && tick;
    assign at_top     = (cnt_q == a_q);
    assign wraps      = (ctl_q.mode != MD_CAPT) && at_top;
    assign period_end = step && wraps;
    assign cap_hit    = (ctl_q.mode == MD_CAPT) && cap_rise;
    assign ppg_mode   = (ctl_q.mode == MD_ONCE) || (ctl_q.mode == MD_LOOP);

    mt16_edge u_ext (.clk(clk), .rst(rst), .din(ext_clk), .rise(ext_rise));
    mt16_edge u_cap (.clk(clk), .rst(rst), .din(cap_in),  .rise(cap_rise));

    mt16_prescale u_pre (
        .clk (clk),
        .rst (rst),
        .clr (pre_clr),
        .sel (ctl_q.csel),
        .tick(pre_tick)
    );

    // control register
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (ctl_wr) begin
            ctl_q.start <= wr_data[BIT_START];
            ctl_q.mode  <= mode_e'(wr_data[5:4]);
            ctl_q.csel  <= wr_data[2:0];
        end else if (period_end && ctl_q.mode == MD_ONCE) begin
            ctl_q.start <= 1'b0;
        end
    end

    // data registers; a capture wins over a bus write to B
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '1;
            b_q <= '0;
        end else begin
            if (wr_en && addr == ADR_A) a_q <= wr_data;
            if (cap_hit)                       b_q <= cnt_q;
            else if (wr_en && addr == ADR_B)   b_q <= wr_data;
        end
    end

    // shared counter
    always_ff @(posedge clk) begin
        if (rst || sw_clr)  cnt_q <= '0;
        else if (step)      cnt_q <= wraps ? '0 : cnt_q + 1'b1;
    end

    // event outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
            cmp_q <= 1'b0;
        end else begin
            irq_q <= period_end || cap_hit;
            if (period_end && ctl_q.mode == MD_COUNT) cmp_q <= ~cmp_q;
        end
    end

    assign irq     = irq_q;
    assign cmp_out = cmp_q;
    assign pwm_out = ctl_q.start && ppg_mode && (cnt_q < b_q);

    always_comb begin
        case (addr)
            ADR_A:   rd_data = a_q;
            ADR_B:   rd_data = b_q;
            ADR_CTL: rd_data = CW'({ctl_q.start, ctl_q.mode, 1'b0, ctl_q.csel});
            default: rd_data = cnt_q;
        endcase
    end

    // ---- assertions ----
    assert_hold_no_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!step && !sw_clr) |=> $stable(cnt_q));

    assert_match_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.mode == MD_COUNT && step && at_top && !sw_clr) |=> (cnt_q == '0 && irq));

    assert_sw_clear_R6: assert property (@(posedge clk) disable iff (rst)
        sw_clr |=> (cnt_q == '0));

    assert_capture_copy_R7: assert property (@(posedge clk) disable iff (rst)
        cap_hit |=> (b_q == $past(cnt_q) && irq));

    assert_oneshot_stop_R11: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.mode == MD_ONCE && period_end && !ctl_wr) |=> (!ctl_q.start && cnt_q == '0 && !pwm_out));
endmodule

// File: tb/sim_mt16_timer.sv
module sim_mt16_timer;
    import mt16_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        ext_clk = 1'b0;
    logic        cap_in = 1'b0;
    logic        irq, cmp_out, pwm_out;

    always #4 clk = ~clk;

    mt16_timer u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .ext_clk(ext_clk), .cap_in(cap_in),
        .irq(irq), .cmp_out(cmp_out), .pwm_out(pwm_out)
    );

    typedef struct {
        int          src;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sbq[$];
    event  mon_ev;
    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;

    localparam int S_RD = 0, S_IRQ = 1, S_CMP = 2, S_PWM = 3;

    // monitor: pops expected items and compares with the design
    always @(mon_ev) begin
        while (sbq.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = sbq.pop_front();
            case (it.src)
                S_RD:    act = rd_data;
                S_IRQ:   act = {15'd0, irq};
                S_CMP:   act = {15'd0, cmp_out};
                default: act = {15'd0, pwm_out};
            endcase
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    // driver side: push an expectation and wake the monitor
    task automatic expect_item(int src, logic [1:0] a, logic [15:0] exp, string tag);
        addr = a;
        #1;
        sbq.push_back('{src, exp, tag});
        ->mon_ev;
        #0;
    endtask

    task automatic rd(logic [1:0] a, logic [15:0] exp, string tag);
        expect_item(S_RD, a, exp, tag);
    endtask

    task automatic pin(int src, logic v, string tag);
        expect_item(src, ADR_CNT, {15'd0, v}, tag);
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [15:0] cw(bit clr, bit start, logic [1:0] md, logic [2:0] sel);
        return {8'h00, clr, start, md, 1'b0, sel};
    endfunction

    task automatic waitn(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up();
        #1;
        ->mon_ev;
        #1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_up();
        end
    end

    initial begin
        waitn(3);
        rst = 1'b0;
        waitn(1);
        // R1 reset state
        rd(ADR_CNT, 16'h0000, "R1 count");
        rd(ADR_CTL, 16'h0000, "R1 ctrl");
        rd(ADR_A,   16'hFFFF, "R1 A");
        rd(ADR_B,   16'h0000, "R1 B");
        pin(S_IRQ, 1'b0, "R1 irq");
        pin(S_CMP, 1'b0, "R1 cmp");
        pin(S_PWM, 1'b0, "R1 pwm");

        // R4/R5 timer match at A=5
        wr(ADR_A, 16'd5);
        rd(ADR_A, 16'd5, "R12 A readback");
        wr(ADR_CTL, cw(1, 1, 2'd0, 3'd0));
        rd(ADR_CNT, 16'd0, "R4 start");
        waitn(3);
        rd(ADR_CNT, 16'd3, "R4 counting");
        waitn(3);
        rd(ADR_CNT, 16'd0, "R4 wrap");
        pin(S_IRQ, 1'b1, "R4 irq pulse");
        pin(S_CMP, 1'b1, "R5 toggle 1");
        waitn(1);
        pin(S_IRQ, 1'b0, "R4 irq one cycle");
        rd(ADR_CNT, 16'd1, "R4 after wrap");
        waitn(5);
        pin(S_CMP, 1'b0, "R5 toggle 2");

        // R2 start gating
        wr(ADR_CTL, cw(1, 0, 2'd0, 3'd0));
        waitn(5);
        rd(ADR_CNT, 16'd0, "R2 held without start");

        // R2 prescaler ratios
        wr(ADR_A, 16'hFFFF);
        wr(ADR_CTL, cw(1, 1, 2'd0, 3'd3));
        waitn(7);
        rd(ADR_CNT, 16'd0, "R2 div8 before");
        waitn(1);
        rd(ADR_CNT, 16'd1, "R2 div8 first");
        waitn(8);
        rd(ADR_CNT, 16'd2, "R2 div8 second");
        wr(ADR_CTL, cw(1, 1, 2'd0, 3'd1));
        waitn(1);
        rd(ADR_CNT, 16'd0, "R2 div2 before");
        waitn(1);
        rd(ADR_CNT, 16'd1, "R2 div2 first");
        wr(ADR_CTL, cw(1, 1, 2'd0, 3'd6));
        waitn(2047);
        rd(ADR_CNT, 16'd0, "R2 div2048 before");
        waitn(1);
        rd(ADR_CNT, 16'd1, "R2 div2048 first");

        // R6 software clear in capture mode
        wr(ADR_CTL, cw(1, 1, 2'd1, 3'd0));
        waitn(10);
        rd(ADR_CNT, 16'd10, "R7 free run");
        wr(ADR_CTL, cw(1, 1, 2'd1, 3'd0));
        rd(ADR_CNT, 16'd0, "R6 clear");
        rd(ADR_CTL, 16'h0050, "R6 clear bit reads 0");

        // R7 capture
        cap_in = 1'b1;
        waitn(3);
        rd(ADR_B, 16'd2, "R7 capture value");
        pin(S_IRQ, 1'b1, "R7 irq");
        rd(ADR_CNT, 16'd3, "R7 counter undisturbed");
        waitn(1);
        pin(S_IRQ, 1'b0, "R7 irq one cycle");
        cap_in = 1'b0;
        waitn(4);
        cap_in = 1'b1;
        waitn(3);
        rd(ADR_B, 16'd10, "R7 second capture");
        waitn(5);
        rd(ADR_B, 16'd10, "R7 level no recapture");
        cap_in = 1'b0;

        // R8 capture ignored in timer mode
        wr(ADR_CTL, cw(1, 1, 2'd0, 3'd0));
        waitn(2);
        cap_in = 1'b1;
        waitn(3);
        pin(S_IRQ, 1'b0, "R8 no irq");
        waitn(2);
        rd(ADR_B, 16'd10, "R8 B unchanged");
        cap_in = 1'b0;

        // R3 external clock
        wr(ADR_CTL, cw(1, 1, 2'd0, 3'd7));
        rd(ADR_CNT, 16'd0, "R3 cleared");
        ext_clk = 1'b1;
        waitn(2);
        rd(ADR_CNT, 16'd0, "R3 latency");
        waitn(1);
        rd(ADR_CNT, 16'd1, "R3 first edge");
        waitn(5);
        rd(ADR_CNT, 16'd1, "R3 held level");
        ext_clk = 1'b0;
        waitn(3);
        ext_clk = 1'b1;
        waitn(3);
        rd(ADR_CNT, 16'd2, "R3 second edge");

        // R9/R10 repeating pulse, A=4 B=2
        wr(ADR_A, 16'd4);
        wr(ADR_B, 16'd2);
        wr(ADR_CTL, cw(1, 1, 2'd3, 3'd0));
        pin(S_PWM, 1'b1, "R9 high at zero");
        waitn(2);
        pin(S_PWM, 1'b0, "R9 low at B");
        waitn(2);
        rd(ADR_CNT, 16'd4, "R9 at A");
        pin(S_IRQ, 1'b0, "R9 no early irq");
        waitn(1);
        rd(ADR_CNT, 16'd0, "R9 period end");
        pin(S_PWM, 1'b1, "R10 next period");
        pin(S_IRQ, 1'b1, "R9 irq");
        waitn(5);
        pin(S_PWM, 1'b1, "R10 third period");
        pin(S_CMP, 1'b0, "R5 no toggle in pulse mode");

        // R11 one-shot, A=3 B=1
        wr(ADR_A, 16'd3);
        wr(ADR_B, 16'd1);
        wr(ADR_CTL, cw(1, 1, 2'd2, 3'd0));
        pin(S_PWM, 1'b1, "R11 pulse high");
        waitn(1);
        pin(S_PWM, 1'b0, "R11 pulse low");
        waitn(3);
        rd(ADR_CNT, 16'd0, "R11 end");
        pin(S_IRQ, 1'b1, "R11 irq");
        rd(ADR_CTL, 16'h0020, "R11 start cleared");
        waitn(4);
        rd(ADR_CNT, 16'd0, "R11 stays zero");
        pin(S_PWM, 1'b0, "R11 stays low");
        wr(ADR_CTL, cw(0, 1, 2'd2, 3'd0));
        pin(S_PWM, 1'b1, "R11 rearmed");
        waitn(4);
        pin(S_PWM, 1'b0, "R11 stops again");
        rd(ADR_CTL, 16'h0020, "R11 start cleared again");

        done = 1'b1;
        finish_up();
    end
endmodule